// File: doc/BRIEF.md
# Interrupt Acknowledge Cycle Sequencer

This block sits between a processor and a serial peripheral. The processor marks an interrupt acknowledge cycle only by driving its active-low opcode-fetch strobe and its active-low I/O request low at the same time. It issues no dedicated acknowledge strobe and no read strobe for that cycle. The peripheral needs both, in a fixed order. The block passes the two processor strobes through a synchronizer. When it sees both low, it pulls the peripheral's active-low acknowledge line low and asserts the processor's active-low wait input.

The peripherals on the interrupt priority daisy chain then need time to settle. That window is the larger of the acknowledge-to-read setup time and the worst-case propagation through the chain. A small input lengthens it by extra clocks when more devices are chained. After the window the block pulls the peripheral read strobe low. It keeps wait asserted until the vector on the data bus is valid and meets the processor's setup time, then releases wait so the processor samples the bus.

The release follows a fixed order: wait first, then the read strobe, then the acknowledge line one clock later. The block re-arms only after both processor strobes have been seen high again. No return-from-interrupt decoding is done, because the peripheral's in-service flags are cleared by software commands. All intervals are whole clock counts, rounded up from nanosecond parameters.

Top module: `irq_ack_sequencer`

## Requirements
- R1: In reset, and when re-entering the idle state, per_ack_n, per_read_n and cpu_wait_n are all high (inactive). A reset in the middle of a sequence returns all three outputs high on the next clock.
- R2: When cpu_fetch_n and cpu_ioreq_n are both low before a rising edge, per_ack_n and cpu_wait_n go low after the third rising edge from that one. Two edges are taken by the two-stage synchronizer and one by the output register.
- R3: An I/O access with cpu_fetch_n high, or a fetch with cpu_ioreq_n high, never starts a sequence. All outputs stay high.
- R4: per_read_n falls exactly SETUP + chain_extra clocks after per_ack_n falls. SETUP = max(ceil(130 ns / T), ceil(CHAIN_DEVICES × 175 ns / T)), where T is the clock period; this is 18 at 10 ns and one device. chain_extra is taken on the clock that starts the sequence.
- R5: cpu_wait_n stays low from the start of the sequence until READ clocks after per_read_n falls, then goes high. READ = max(ceil(125 ns / T), ceil((120 ns + 25 ns) / T)), which is 15 at 10 ns.
- R6: per_read_n rises HOLD clocks after cpu_wait_n rises (HOLD = 1 by default). per_ack_n rises exactly one clock after per_read_n rises.
- R7: After per_ack_n rises, no new sequence starts until both processor strobes have been seen high. Holding them low does not retrigger. A one-clock high gap is enough to re-arm.
- R8: per_read_n is never low while per_ack_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock that times every interval |
| rst | input | 1 | Synchronous active-high reset |
| cpu_fetch_n | input | 1 | Processor opcode-fetch strobe, active low, asynchronous |
| cpu_ioreq_n | input | 1 | Processor I/O request strobe, active low, asynchronous |
| chain_extra | input | EXTRA_W | Extra settle clocks added to the daisy-chain window |
| per_ack_n | output | 1 | Peripheral interrupt acknowledge strobe, active low |
| per_read_n | output | 1 | Peripheral read strobe, active low |
| cpu_wait_n | output | 1 | Processor wait request, active low |

## Verification
The hardest situations to reach are those where the processor strobes change at awkward points. One is a strobe pair that stays low far past the end of the sequence. Others are a one-clock high gap between two acknowledge cycles and a reset that lands inside the read phase while the strobes are still low. The stimulus drives each of these on purpose: long holds, a single-clock release followed at once by a new acknowledge, a short low pulse, and a mid-read reset. A cycle-accurate timeline model built from absolute cycle stamps predicts every output on every clock. The largest chain_extra value exercises the longest settle window.

// File: rtl/iack_pkg.sv
package iack_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ACK_SETUP,
    ST_READ_ACTIVE,
    ST_RELEASE,
    ST_WAIT_END
  } iack_state_e;

  function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
    return (num + den - 1) / den;
  endfunction

  function automatic int unsigned max_u(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/iack_sync.sv
module iack_sync #(
  parameter int          WIDTH   = 2,
  parameter int          STAGES  = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= RST_VAL;
        else     stage_q[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stage_q[g] <= RST_VAL;
        else     stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/iack_timer.sv
module iack_timer #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);

  logic [W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst)                  remain_q <= '0;
    else if (load)            remain_q <= load_val;
    else if (remain_q != '0)  remain_q <= remain_q - 1'b1;
  end

  assign expired = (remain_q == '0);

endmodule

// File: rtl/irq_ack_sequencer.sv
module irq_ack_sequencer
  import iack_pkg::*;
#(
  parameter int unsigned CLK_PERIOD_NS   = 10,
  parameter int unsigned ACK_SETUP_NS    = 130,
  parameter int unsigned CHAIN_DEVICES   = 1,
  parameter int unsigned CHAIN_HOP_NS    = 175,
  parameter int unsigned READ_WIDTH_NS   = 125,
  parameter int unsigned VECTOR_VALID_NS = 120,
  parameter int unsigned CPU_SETUP_NS    = 25,
  parameter int unsigned HOLD_CLKS       = 1,
  parameter int unsigned EXTRA_W         = 4,
  parameter int unsigned SYNC_STAGES     = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               cpu_fetch_n,
  input  logic               cpu_ioreq_n,
  input  logic [EXTRA_W-1:0] chain_extra,
  output logic               per_ack_n,
  output logic               per_read_n,
  output logic               cpu_wait_n
);

  localparam int unsigned SETUP_CLKS = max_u(max_u(1, ceil_div(ACK_SETUP_NS, CLK_PERIOD_NS)),
                                             ceil_div(CHAIN_DEVICES * CHAIN_HOP_NS, CLK_PERIOD_NS));
  localparam int unsigned RD_CLKS    = max_u(max_u(1, ceil_div(READ_WIDTH_NS, CLK_PERIOD_NS)),
                                             ceil_div(VECTOR_VALID_NS + CPU_SETUP_NS, CLK_PERIOD_NS));
  localparam int unsigned HOLD_EFF   = max_u(1, HOLD_CLKS);
  localparam int unsigned SPAN       = max_u(SETUP_CLKS + (1 << EXTRA_W), max_u(RD_CLKS, HOLD_EFF));
  localparam int unsigned CNT_W      = $clog2(SPAN + 1);

  // Strobe synchronizer
  logic [1:0] strobe_s;
  logic       ack_seen;
  logic       bus_idle;

  iack_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({cpu_fetch_n, cpu_ioreq_n}),
    .q   (strobe_s)
  );

  assign ack_seen = (strobe_s == 2'b00);
  assign bus_idle = (strobe_s == 2'b11);

  // Phase timer
  iack_state_e      state_q;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             tmr_done;

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (state_q)
      ST_IDLE: begin
        tmr_load = ack_seen;
        tmr_val  = CNT_W'(SETUP_CLKS - 1) + CNT_W'(chain_extra);
      end
      ST_ACK_SETUP: begin
        tmr_load = tmr_done;
        tmr_val  = CNT_W'(RD_CLKS - 1);
      end
      ST_READ_ACTIVE: begin
        tmr_load = tmr_done;
        tmr_val  = CNT_W'(HOLD_EFF - 1);
      end
      default: begin
        tmr_load = 1'b0;
        tmr_val  = '0;
      end
    endcase
  end

  iack_timer #(.W(CNT_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .expired  (tmr_done)
  );

  // Sequencer with registered outputs
  logic ack_q, read_q, wait_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      ack_q   <= 1'b1;
      read_q  <= 1'b1;
      wait_q  <= 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (ack_seen) begin
            state_q <= ST_ACK_SETUP;
            ack_q   <= 1'b0;
            wait_q  <= 1'b0;
          end
        end
        ST_ACK_SETUP: begin
          if (tmr_done) begin
            state_q <= ST_READ_ACTIVE;
            read_q  <= 1'b0;
          end
        end
        ST_READ_ACTIVE: begin
          if (tmr_done) begin
            state_q <= ST_RELEASE;
            wait_q  <= 1'b1;
          end
        end
        ST_RELEASE: begin
          if (tmr_done) begin
            state_q <= ST_WAIT_END;
            read_q  <= 1'b1;
          end
        end
        ST_WAIT_END: begin
          ack_q <= 1'b1;
          if (bus_idle) state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign per_ack_n  = ack_q;
  assign per_read_n = read_q;
  assign cpu_wait_n = wait_q;

  // Interval counters feeding the assertions
  logic [CNT_W:0] ack_low_cnt, read_low_cnt;

  always_ff @(posedge clk) begin
    if (rst || per_ack_n)          ack_low_cnt <= '0;
    else if (ack_low_cnt != '1)    ack_low_cnt <= ack_low_cnt + 1'b1;
    if (rst || per_read_n)         read_low_cnt <= '0;
    else if (read_low_cnt != '1)   read_low_cnt <= read_low_cnt + 1'b1;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE) |-> (per_ack_n && per_read_n && cpu_wait_n)); // R1
  AST_START_NEEDS_BOTH: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(per_ack_n)) |-> $past(ack_seen)); // R3
  AST_SETUP_MIN: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(per_read_n)) |-> (ack_low_cnt >= (CNT_W+1)'(SETUP_CLKS))); // R4
  AST_WAIT_AT_READ: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $fell(per_read_n)) |-> !cpu_wait_n); // R5
  AST_READ_WIDTH: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(per_read_n)) |-> (read_low_cnt >= (CNT_W+1)'(RD_CLKS))); // R5
  AST_ACK_AFTER_READ: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $rose(per_ack_n)) |-> $past(per_read_n)); // R6
  AST_READ_UNDER_ACK: assert property (@(posedge clk) disable iff (rst)
    !per_read_n |-> !per_ack_n); // R8

endmodule

// File: tb/test_irq_ack_sequencer.sv
module test_irq_ack_sequencer;

  // Expected intervals from the requirements at a 10 ns clock
  localparam int SETUP_EXP = 18;  // R4: max(ceil(130/10), ceil(175/10))
  localparam int READ_EXP  = 15;  // R5: max(ceil(125/10), ceil(145/10))
  localparam int HOLD_EXP  = 1;   // R6

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic       rst = 1'b1;
  logic       fetch_n = 1'b1;
  logic       ioreq_n = 1'b1;
  logic [3:0] extra = 4'd0;
  logic       ack_n, read_n, wait_n;

  irq_ack_sequencer i_irq_ack_sequencer (
    .clk         (clk),
    .rst         (rst),
    .cpu_fetch_n (fetch_n),
    .cpu_ioreq_n (ioreq_n),
    .chain_extra (extra),
    .per_ack_n   (ack_n),
    .per_read_n  (read_n),
    .cpu_wait_n  (wait_n)
  );

  int    compared = 0;
  int    mismatched = 0;
  int    cyc = 0;
  string tag = "R1";

  // Behavioural timeline model
  logic [1:0] hist[$];
  bit         busy = 1'b0;
  int         t0 = 0;
  int         n_set = 0;
  logic       e_ack = 1'b1, e_read = 1'b1, e_wait = 1'b1;

  always @(posedge clk) begin
    logic [1:0] s;
    cyc = cyc + 1;
    if (rst) begin
      busy = 1'b0;
      hist = '{2'b11, 2'b11};
    end else begin
      s = hist.pop_front();
      hist.push_back({fetch_n, ioreq_n});
      if (!busy) begin
        if (s == 2'b00) begin
          busy  = 1'b1;
          t0    = cyc;
          n_set = SETUP_EXP + int'(extra);
        end
      end else if (cyc >= t0 + n_set + READ_EXP + HOLD_EXP + 1 && s == 2'b11) begin
        busy = 1'b0;
      end
    end
    e_ack  = !(busy && cyc < t0 + n_set + READ_EXP + HOLD_EXP + 1);
    e_read = !(busy && cyc >= t0 + n_set && cyc < t0 + n_set + READ_EXP + HOLD_EXP);
    e_wait = !(busy && cyc < t0 + n_set + READ_EXP);
  end

  task automatic check(input string what, input logic act, input logic exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s %s at cycle %0d: actual=%b expected=%b", tag, what, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (cyc > 0) begin
      check("per_ack_n", ack_n, e_ack);
      check("per_read_n", read_n, e_read);
      check("cpu_wait_n", wait_n, e_wait);
      if (!rst) begin
        // R8: read never low while acknowledge is high
        compared++;
        if (!read_n && ack_n) begin
          mismatched++;
          $display("FAIL R8 read-under-ack at cycle %0d: actual=%b%b expected=ack low", cyc, ack_n, read_n);
        end
      end
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc > 20000) begin
      mismatched++;
      $display("FAIL watchdog: actual=running expected=done");
      finish_run();
    end
  end

  task automatic wait_cycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobes(input logic f, input logic r, input int n);
    fetch_n = f;
    ioreq_n = r;
    wait_cycles(n);
  endtask

  initial begin
    tag = "R1";
    wait_cycles(3);
    rst = 1'b0;
    wait_cycles(5);

    tag = "R3";  // plain I/O access, then fetch alone
    strobes(1'b1, 1'b0, 30);
    strobes(1'b0, 1'b1, 30);
    strobes(1'b1, 1'b1, 5);

    tag = "R2";  // full acknowledge, strobes held far past the end (also R7)
    strobes(1'b0, 1'b0, 70);
    strobes(1'b1, 1'b1, 10);

    tag = "R4";  // chain lengthened by five clocks
    extra = 4'd5;
    strobes(1'b0, 1'b0, 80);
    strobes(1'b1, 1'b1, 10);

    tag = "R5";  // longest settle window, wait and read timing
    extra = 4'd15;
    strobes(1'b0, 1'b0, 90);
    strobes(1'b1, 1'b1, 10);
    extra = 4'd0;

    tag = "R7";  // short pulse, then back-to-back with a one-clock gap
    strobes(1'b0, 1'b0, 3);
    strobes(1'b1, 1'b1, 50);
    strobes(1'b0, 1'b0, 50);
    strobes(1'b1, 1'b1, 1);
    strobes(1'b0, 1'b0, 50);
    strobes(1'b1, 1'b1, 10);

    tag = "R6";  // release order checked on each clock
    strobes(1'b0, 1'b0, 45);
    strobes(1'b1, 1'b1, 10);

    tag = "R1";  // reset in the read phase with strobes still low
    fetch_n = 1'b0;
    ioreq_n = 1'b0;
    wait_cycles(25);
    rst = 1'b1;
    wait_cycles(2);
    rst = 1'b0;
    wait_cycles(60);
    strobes(1'b1, 1'b1, 10);

    tag = "R8";
    wait_cycles(5);
    finish_run();
  end

endmodule